// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs one management transaction to an external PHY each time a host loads a 32-bit command word into it. The word holds the complete serial frame: start pattern, operation code, PHY address, register address, turnaround pattern and sixteen data bits. The engine sends nothing of its own apart from a preamble of ones. It takes the word as given and shifts it out most significant bit first on a management clock it generates. For a read it stops driving the data line from the second turnaround bit onward. It then samples the sixteen bits the PHY returns into the low half of the same word.

The host follows progress through an idle flag, which is low while a frame is on the wire. A one-cycle done pulse marks the end of each frame and can serve as an interrupt source. A 3-bit selector sets the management clock rate from the system clock. The engine latches the selector together with the command word, so the rate stays the same for the whole frame.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset the engine is idle (`eng_idle`=1), `mdc`=0, `mdio_oe`=0, `mgmt_done`=0 and `maint_rdata`=0.
- R2: A `maint_wr` pulse while idle loads `maint_wdata` into the command word and drives `eng_idle` low from the next cycle.
- R3: Each frame begins with 32 `mdc` periods in which `mdio_o` is 1 and `mdio_oe` is 1.
- R4: After the preamble, a frame whose command word bits 29:28 are not 10 sends all 32 command bits from bit 31 down to bit 0, with `mdio_oe`=1 throughout.
- R5: `mdio_o` changes only after a falling edge of `mdc` (or when a frame starts), so it is steady at every rising edge while driven.
- R6: `mdc` stays high for 2<<sel system cycles and low for 2<<sel system cycles, where sel is `mdc_div_sel` as captured at the start of the frame. Outside frames `mdc` stays low.
- R7: When command bits 29:28 are 10 (read), command bits 31:17 go out driven after the preamble. `mdio_oe` then falls for the rest of the frame. The first 16 sampled bits, in order, become `maint_rdata[15:0]`, and bits 31:16 keep their written value.
- R8: Each frame ends with exactly one `mgmt_done` pulse of one cycle, in the same cycle that `eng_idle` returns to 1.
- R9: A `maint_wr` while a frame is in progress is ignored. The frame on the wire, the final command word and the clock rate are unaffected.
- R10: A frame lasts exactly 64 `mdc` periods. For a write frame the command word reads back unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| maint_wr | input | 1 | Load command word and start a frame (when idle) |
| maint_wdata | input | 32 | Command word (frame bits) |
| mdc_div_sel | input | 3 | Management clock divider selector |
| maint_rdata | output | 32 | Command word; low half holds read data after a read |
| eng_idle | output | 1 | 1 when no frame is in progress |
| mgmt_done | output | 1 | One-cycle pulse at end of each frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench builds the engine with its default parameters: a 32-bit preamble, a 32-bit command word and a base half period of two system cycles. With these values the shortest management clock of four system cycles per period is in use, so many frames fit in a run. Divider selectors 0 to 2 come up in random frames, and a directed frame uses selector 4 to confirm the shift. A behavioural PHY model samples every rising edge of the management clock and returns random read data. This brings the release point of a read, and the handling of a command written mid-frame, within reach.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Operation code field values (command word bits 29:28)
  typedef enum logic [1:0] {
    MOP_WRITE = 2'b01,
    MOP_READ  = 2'b10
  } mdio_op_e;

  // Half period of the management clock in system cycles.
  function automatic int unsigned half_cycles(input logic [2:0] sel,
                                              input int unsigned base);
    return base << sel;
  endfunction

  // Word bit position sent at frame slot k (slot counts from preamble start).
  function automatic int unsigned word_pos(input int unsigned k,
                                           input int unsigned pre_len,
                                           input int unsigned word_w);
    return word_w - 1 - (k - pre_len);
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W     = 3,
  parameter int unsigned HALF_BASE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] sel,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int unsigned MAX_HALF = HALF_BASE << ((1 << DIV_W) - 1);
  localparam int unsigned CNT_W    = $clog2(MAX_HALF) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_m1;
  logic             tick;

  always_comb begin
    lim_m1 = CNT_W'(half_cycles(3'(sel), HALF_BASE) - 1);
    tick   = run && (cnt == lim_m1);
  end

  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: management clock parked low between frames
  a_r6_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);

  // R6: clock edges only follow a completed half period
  a_r6_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mdc));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned OP_LO   = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word_in,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] word_q,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int unsigned FRAME_LEN = PRE_LEN + WORD_W;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  localparam int unsigned WIDX_W    = $clog2(WORD_W);
  // slot where a read releases the line (second turnaround bit)
  localparam int unsigned REL_SLOT  = FRAME_LEN - DATA_W - 1;
  localparam int unsigned CAP_SLOT  = FRAME_LEN - DATA_W;

  logic [IDX_W-1:0]  idx;
  logic              is_read;
  logic              in_pre;
  logic              drive_bit;
  logic [WIDX_W-1:0] wpos;
  logic              last_slot;
  logic              cap_en;

  always_comb begin
    is_read   = (word_q[OP_LO+1:OP_LO] == MOP_READ);
    in_pre    = (idx < IDX_W'(PRE_LEN));
    wpos      = WIDX_W'(word_pos(32'(idx), PRE_LEN, WORD_W));
    drive_bit = in_pre ? 1'b1 : word_q[wpos];
    last_slot = (idx == IDX_W'(FRAME_LEN - 1));
    cap_en    = busy && is_read && rise_tick && (idx >= IDX_W'(CAP_SLOT));
    mdio_oe   = busy && (!is_read || (idx < IDX_W'(REL_SLOT)));
    mdio_o    = mdio_oe ? drive_bit : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      idx    <= '0;
      word_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          idx    <= '0;
          word_q <= word_in;
        end
      end else begin
        if (cap_en)
          word_q[DATA_W-1:0] <= {word_q[DATA_W-2:0], mdio_i};
        if (fall_tick) begin
          if (last_slot) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  // R5: the driven line is steady across a rising clock edge
  a_r5_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick && mdio_oe |=> $stable(mdio_o));

  // R3: preamble slots drive ones
  a_r3_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busy && in_pre |-> mdio_oe && mdio_o);

  // R8: done lasts one cycle and coincides with the end of busy
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  // R9: upper part of the command word holds during a frame
  a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(word_q[WORD_W-1:DATA_W]));

  // R10: a frame ends only on a falling clock edge of the last slot
  a_r10_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fall_tick));

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN   = 32,
  parameter int unsigned DIV_W     = 3,
  parameter int unsigned HALF_BASE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        maint_wr,
  input  logic [31:0] maint_wdata,
  input  logic [2:0]  mdc_div_sel,
  output logic [31:0] maint_rdata,
  output logic        eng_idle,
  output logic        mgmt_done,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int unsigned WORD_W = 32;
  localparam int unsigned DATA_W = 16;

  logic             busy;
  logic             rise_tick;
  logic             fall_tick;
  logic             accept;
  logic [DIV_W-1:0] sel_q;

  assign accept = maint_wr && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= '0;
    else if (accept)
      sel_q <= DIV_W'(mdc_div_sel);
  end

  mdio_clkgen #(
    .DIV_W     (DIV_W),
    .HALF_BASE (HALF_BASE)
  ) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .sel       (sel_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq #(
    .PRE_LEN (PRE_LEN),
    .WORD_W  (WORD_W),
    .DATA_W  (DATA_W),
    .OP_LO   (28)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .word_in   (maint_wdata),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .done      (mgmt_done),
    .word_q    (maint_rdata),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  assign eng_idle = !busy;

  // R2: an accepted command makes the engine busy on the next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !eng_idle);

  // R9: divider selector frozen for the frame
  a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sel_q));

endmodule

// File: tb/mdio_mgmt_engine_bench.sv
module mdio_mgmt_engine_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        maint_wr = 1'b0;
  logic [31:0] maint_wdata = '0;
  logic [2:0]  mdc_div_sel = '0;
  logic [31:0] maint_rdata;
  logic        eng_idle, mgmt_done, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  mdio_mgmt_engine u_mdio_mgmt_engine (
    .clk (clk), .rst_n (rst_n), .maint_wr (maint_wr),
    .maint_wdata (maint_wdata), .mdc_div_sel (mdc_div_sel),
    .maint_rdata (maint_rdata), .eng_idle (eng_idle),
    .mgmt_done (mgmt_done), .mdc (mdc), .mdio_o (mdio_o),
    .mdio_oe (mdio_oe), .mdio_i (mdio_i)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // PHY model and line recorder
  logic [63:0] rec_bits, rec_oe;
  int          rises, half_bad, exp_half, done_cnt, done_bad;
  logic [15:0] phy_data;
  time         t_rise, t_fall;

  always @(posedge mdc) begin
    rec_bits = {rec_bits[62:0], mdio_o};
    rec_oe   = {rec_oe[62:0], mdio_oe};
    if (rises > 0 && (($time - t_fall) / PERIOD) != exp_half) half_bad++;
    rises++;
    t_rise = $time;
  end

  always @(negedge mdc) begin
    if ((($time - t_rise) / PERIOD) != exp_half) half_bad++;
    t_fall = $time;
    if (rises >= 48 && rises < 64) mdio_i = phy_data[63 - rises];
    else mdio_i = 1'($urandom_range(0, 1));
  end

  always @(negedge clk) begin
    if (mgmt_done) begin
      done_cnt++;
      if (!eng_idle) done_bad++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int half_of(input logic [2:0] s);
    return 2 * (1 << s);
  endfunction

  function automatic bit is_rd(input logic [31:0] w);
    return w[29:28] == 2'b10;
  endfunction

  task automatic run_frame(input logic [31:0] w, input logic [2:0] s,
                           input bit poke_busy);
    int wait_n;
    logic [63:0] exp_bits, exp_oe;
    rises = 0; half_bad = 0; done_cnt = 0; done_bad = 0;
    rec_bits = '0; rec_oe = '0;
    exp_half = half_of(s);
    phy_data = 16'($urandom);
    @(negedge clk);
    maint_wr = 1'b1; maint_wdata = w; mdc_div_sel = s;
    @(negedge clk);
    maint_wr = 1'b0; maint_wdata = 32'($urandom); mdc_div_sel = 3'($urandom);
    check(eng_idle == 1'b0, "R2 idle low after start", 64'(eng_idle), 64'd0);
    if (poke_busy) begin
      repeat (100) @(negedge clk);
      maint_wr = 1'b1; maint_wdata = ~w; mdc_div_sel = s + 3'd1;
      @(negedge clk);
      maint_wr = 1'b0;
    end
    wait_n = 0;
    while (!eng_idle && wait_n < 80000) begin
      @(negedge clk);
      wait_n++;
    end
    check(wait_n < 80000, "R8 frame completes", 64'(wait_n), 64'd0);
    repeat (3) @(negedge clk);
    check(rises == 64, "R10 frame length in mdc periods", 64'(rises), 64'd64);
    check(half_bad == 0, "R6 mdc half period", 64'(half_bad), 64'd0);
    check(done_cnt == 1 && done_bad == 0, "R8 single done with idle",
          64'(done_cnt), 64'd1);
    check(rec_bits[63:32] == 32'hFFFF_FFFF && rec_oe[63:32] == 32'hFFFF_FFFF,
          "R3 preamble", rec_bits, 64'hFFFF_FFFF_0000_0000);
    check(mdc == 1'b0, "R6 mdc low after frame", 64'(mdc), 64'd0);
    if (is_rd(w)) begin
      exp_bits = {32'hFFFF_FFFF, w};
      exp_oe   = {47'h7FFF_FFFF_FFFF, 17'h0};
      check(rec_bits[63:17] == exp_bits[63:17], "R7 read header bits",
            rec_bits, exp_bits);
      check(rec_oe == exp_oe, "R7 read release point", rec_oe, exp_oe);
      check(maint_rdata == {w[31:16], phy_data}, "R7 captured read data",
            64'(maint_rdata), 64'({w[31:16], phy_data}));
    end else begin
      exp_bits = {32'hFFFF_FFFF, w};
      check(rec_bits == exp_bits, "R4 write frame bits", rec_bits, exp_bits);
      check(rec_oe == '1, "R4 write drives whole frame", rec_oe, '1);
      check(maint_rdata == w, "R10 write word unchanged",
            64'(maint_rdata), 64'(w));
    end
    if (poke_busy)
      check(maint_rdata[31:16] == w[31:16] && half_bad == 0,
            "R9 busy write ignored", 64'(maint_rdata), 64'(w));
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(eng_idle == 1'b1, "R1 idle at reset", 64'(eng_idle), 64'd1);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 lines at reset",
          {62'd0, mdc, mdio_oe}, 64'd0);
    check(mgmt_done == 1'b0, "R1 done at reset", 64'(mgmt_done), 64'd0);
    check(maint_rdata == 32'd0, "R1 word at reset", 64'(maint_rdata), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    run_frame({2'b01, 2'b01, 5'd1, 5'd0, 2'b10, 16'hA5A5}, 3'd0, 0);
    run_frame({2'b01, 2'b10, 5'd31, 5'd31, 2'b10, 16'h0000}, 3'd0, 0);
    run_frame({2'b01, 2'b01, 5'd0, 5'd0, 2'b10, 16'hFFFF}, 3'd4, 0);
    run_frame({2'b01, 2'b10, 5'd7, 5'd2, 2'b10, 16'h0000}, 3'd1, 1);
    run_frame({2'b01, 2'b01, 5'd3, 5'd9, 2'b10, 16'h1234}, 3'd0, 1);
    // random frames
    for (int i = 0; i < 20; i++) begin
      w = $urandom;
      w[31:30] = 2'b01;
      w[29:28] = ($urandom_range(0, 1) == 0) ? 2'b01 : 2'b10;
      w[17:16] = 2'b10;
      run_frame(w, 3'($urandom_range(0, 2)), 0);
    end
    report();
  end
endmodule